// File: doc/BRIEF.md
# Bus Master Security Filter

This block sits between one bus master and one downstream memory port. It decides, for every transaction, whether to let it through and with which security attribute. When a request is accepted, the block reads an external attribution unit. That unit answers combinationally for the request address with two flags: the address is exempt from checking, or the address lies in a non-secure region. The block then forwards the access as secure, forwards it as non-secure, or blocks it. A blocked access either completes quietly, reading zero with writes dropped, or completes with an error and raises a sticky interrupt.

Both sides use a valid/ready request channel and a valid/ready response channel. Only one transaction is in flight at a time. Address, direction, size and little-endian write data pass to the downstream port unchanged. Read data and the error flag come back to the master unchanged. The two configuration inputs are sampled when a request is accepted. The master's security setting is `cfg_nonsec`, and `cfg_sec_resp` selects an error response for blocked accesses. Raising `irq_clear` clears the interrupt status and keeps it clear.

Top module: `bus_sec_filter`

## Requirements
- R1: For an exempt address (`attr_exempt`=1), the access is forwarded with `dn_req_secure` = NOT `cfg_nonsec`.
- R2: For an address that is not exempt and is marked non-secure (`attr_nonsec`=1), the access is forwarded with `dn_req_secure`=0, whatever `cfg_nonsec` is.
- R3: For a secure, non-exempt address with `cfg_nonsec`=0, the access is forwarded with `dn_req_secure`=1.
- R4: For a secure, non-exempt address with `cfg_nonsec`=1, the access is blocked and `dn_req_valid` never rises for it.
- R5: A blocked access with `cfg_sec_resp`=0 completes with `up_rsp_err`=0 and all-zero `up_rsp_rdata`, and it leaves the interrupt status unchanged.
- R6: A blocked access with `cfg_sec_resp`=1 completes with `up_rsp_err`=1 and all-zero read data. It sets the interrupt status from the cycle after acceptance, unless `irq_clear` is high.
- R7: While `irq_clear` is high, the status is cleared on the next clock edge and is not set by aborted accesses. `irq` always equals the status bit.
- R8: After reset, `irq`=0, `up_req_ready`=1, `dn_req_valid`=0 and `up_rsp_valid`=0.
- R9: A forwarded access presents address, write flag, size code (0=1 byte, 1=2, 2=4, 3=8) and write data on the downstream port unchanged. These fields hold steady while `dn_req_valid` waits for `dn_req_ready`.
- R10: A forwarded access returns the downstream `dn_rsp_err` and `dn_rsp_rdata` to the master unchanged.
- R11: `cfg_nonsec` and `cfg_sec_resp` are sampled in the acceptance cycle. Changing them later has no effect on that transaction.
- R12: `up_req_ready` stays low from acceptance until the response handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | 1 | Master request valid |
| up_req_ready | output | 1 | Filter can accept a request |
| up_req_addr | input | ADDR_W | Request address |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_size | input | SIZE_W | log2 of access bytes |
| up_req_wdata | input | DATA_W | Write data, little-endian |
| up_rsp_valid | output | 1 | Response to master valid |
| up_rsp_ready | input | 1 | Master takes the response |
| up_rsp_err | output | 1 | Error response |
| up_rsp_rdata | output | DATA_W | Read data |
| attr_exempt | input | 1 | Lookup: address exempt from checking |
| attr_nonsec | input | 1 | Lookup: address in a non-secure region |
| cfg_nonsec | input | 1 | Master configured non-secure |
| cfg_sec_resp | input | 1 | Blocked accesses return an error |
| irq_clear | input | 1 | Clear and hold off interrupt status |
| irq | output | 1 | Interrupt (status bit) |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream takes the request |
| dn_req_addr | output | ADDR_W | Downstream address |
| dn_req_write | output | 1 | Downstream write flag |
| dn_req_size | output | SIZE_W | Downstream size code |
| dn_req_wdata | output | DATA_W | Downstream write data |
| dn_req_secure | output | 1 | 1 = secure attribute |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_ready | output | 1 | Filter takes the downstream response |
| dn_rsp_err | input | 1 | Downstream error |
| dn_rsp_rdata | input | DATA_W | Downstream read data |

## Verification
The assertions check the properties that can be judged one cycle after acceptance, on every cycle:
- the routing and security attribute chosen from the attribution flags and configuration;
- the absence of a downstream request for a blocked access, and its quiet or error completion;
- clearing of the interrupt by `irq_clear`, and setting it on an abort;
- request stability under backpressure, and the single outstanding transaction.

Only the bench scenarios can show the rest: that data and error codes pass through unchanged end to end, that a configuration change after acceptance leaves the transaction untouched, and that the interrupt stays set across later unrelated traffic.

// File: rtl/sec_filter_pkg.sv
package sec_filter_pkg;

    // Outcome chosen for one accepted request
    typedef enum logic [1:0] {
        ACT_ABORT  = 2'd0,
        ACT_QUIET  = 2'd1,
        ACT_FWD_S  = 2'd2,
        ACT_FWD_NS = 2'd3
    } action_e;

    // Transaction sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DREQ  = 2'd1,
        ST_DWAIT = 2'd2,
        ST_URSP  = 2'd3
    } state_e;

endpackage

// File: rtl/sec_filter_decide.sv
module sec_filter_decide
    import sec_filter_pkg::*;
(
    input  logic    exempt,
    input  logic    region_ns,
    input  logic    master_ns,
    input  logic    err_on_block,
    output action_e act
);

    always_comb begin
        if (exempt) begin
            act = master_ns ? ACT_FWD_NS : ACT_FWD_S;
        end else if (region_ns) begin
            act = ACT_FWD_NS;
        end else if (!master_ns) begin
            act = ACT_FWD_S;
        end else begin
            act = err_on_block ? ACT_ABORT : ACT_QUIET;
        end
    end

endmodule

// File: rtl/sec_filter_irq.sv
module sec_filter_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic set,
    output logic status
);

    logic status_d, status_q;

    always_comb begin
        status_d = status_q;
        if (clear) begin
            status_d = 1'b0;
        end else if (set) begin
            status_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status = status_q;

endmodule

// File: rtl/bus_sec_filter.sv
module bus_sec_filter
    import sec_filter_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_BYTES = 8,
    localparam int DATA_W   = MAX_BYTES * 8,
    localparam int SIZE_W   = $clog2($clog2(MAX_BYTES) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req_valid,
    output logic              up_req_ready,
    input  logic [ADDR_W-1:0] up_req_addr,
    input  logic              up_req_write,
    input  logic [SIZE_W-1:0] up_req_size,
    input  logic [DATA_W-1:0] up_req_wdata,
    output logic              up_rsp_valid,
    input  logic              up_rsp_ready,
    output logic              up_rsp_err,
    output logic [DATA_W-1:0] up_rsp_rdata,
    input  logic              attr_exempt,
    input  logic              attr_nonsec,
    input  logic              cfg_nonsec,
    input  logic              cfg_sec_resp,
    input  logic              irq_clear,
    output logic              irq,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic [ADDR_W-1:0] dn_req_addr,
    output logic              dn_req_write,
    output logic [SIZE_W-1:0] dn_req_size,
    output logic [DATA_W-1:0] dn_req_wdata,
    output logic              dn_req_secure,
    input  logic              dn_rsp_valid,
    output logic              dn_rsp_ready,
    input  logic              dn_rsp_err,
    input  logic [DATA_W-1:0] dn_rsp_rdata
);

    typedef struct packed {
        state_e              state;
        logic [ADDR_W-1:0]   addr;
        logic                write;
        logic [SIZE_W-1:0]   size;
        logic [DATA_W-1:0]   wdata;
        logic                secure;
        logic                rsp_err;
        logic [DATA_W-1:0]   rsp_rdata;
    } ctx_t;

    ctx_t    ctx_d, ctx_q;
    action_e act;
    logic    accept;
    logic    abort_hit;

    sec_filter_decide u_decide (
        .exempt       (attr_exempt),
        .region_ns    (attr_nonsec),
        .master_ns    (cfg_nonsec),
        .err_on_block (cfg_sec_resp),
        .act          (act)
    );

    assign accept    = up_req_valid && (ctx_q.state == ST_IDLE);
    assign abort_hit = accept && (act == ACT_ABORT);

    sec_filter_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (irq_clear),
        .set    (abort_hit),
        .status (irq)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.state)
            ST_IDLE: begin
                if (accept) begin
                    ctx_d.addr  = up_req_addr;
                    ctx_d.write = up_req_write;
                    ctx_d.size  = up_req_size;
                    ctx_d.wdata = up_req_wdata;
                    unique case (act)
                        ACT_FWD_S: begin
                            ctx_d.secure = 1'b1;
                            ctx_d.state  = ST_DREQ;
                        end
                        ACT_FWD_NS: begin
                            ctx_d.secure = 1'b0;
                            ctx_d.state  = ST_DREQ;
                        end
                        ACT_QUIET: begin
                            ctx_d.rsp_err   = 1'b0;
                            ctx_d.rsp_rdata = '0;
                            ctx_d.state     = ST_URSP;
                        end
                        default: begin
                            ctx_d.rsp_err   = 1'b1;
                            ctx_d.rsp_rdata = '0;
                            ctx_d.state     = ST_URSP;
                        end
                    endcase
                end
            end
            ST_DREQ: begin
                if (dn_req_ready) begin
                    ctx_d.state = ST_DWAIT;
                end
            end
            ST_DWAIT: begin
                if (dn_rsp_valid) begin
                    ctx_d.rsp_err   = dn_rsp_err;
                    ctx_d.rsp_rdata = dn_rsp_rdata;
                    ctx_d.state     = ST_URSP;
                end
            end
            default: begin
                if (up_rsp_ready) begin
                    ctx_d.state = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign up_req_ready  = (ctx_q.state == ST_IDLE);
    assign up_rsp_valid  = (ctx_q.state == ST_URSP);
    assign up_rsp_err    = ctx_q.rsp_err;
    assign up_rsp_rdata  = ctx_q.rsp_rdata;
    assign dn_req_valid  = (ctx_q.state == ST_DREQ);
    assign dn_req_addr   = ctx_q.addr;
    assign dn_req_write  = ctx_q.write;
    assign dn_req_size   = ctx_q.size;
    assign dn_req_wdata  = ctx_q.wdata;
    assign dn_req_secure = ctx_q.secure;
    assign dn_rsp_ready  = (ctx_q.state == ST_DWAIT);

endmodule

// File: rtl/bus_sec_filter_chk.sv
module bus_sec_filter_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_req_valid,
    input logic              up_req_ready,
    input logic              up_rsp_valid,
    input logic              up_rsp_ready,
    input logic              up_rsp_err,
    input logic [DATA_W-1:0] up_rsp_rdata,
    input logic              attr_exempt,
    input logic              attr_nonsec,
    input logic              cfg_nonsec,
    input logic              cfg_sec_resp,
    input logic              irq_clear,
    input logic              irq,
    input logic              dn_req_valid,
    input logic              dn_req_ready,
    input logic [ADDR_W-1:0] dn_req_addr,
    input logic              dn_req_secure
);

    logic acc;
    logic blocked;
    assign acc     = up_req_valid && up_req_ready;
    assign blocked = cfg_nonsec && !attr_exempt && !attr_nonsec;

    // R1
    exempt_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && attr_exempt |=> dn_req_valid && (dn_req_secure == !$past(cfg_nonsec)));

    // R2
    ns_region_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !attr_exempt && attr_nonsec |=> dn_req_valid && !dn_req_secure);

    // R3
    sec_master_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !attr_exempt && !attr_nonsec && !cfg_nonsec |=> dn_req_valid && dn_req_secure);

    // R4
    block_no_downstream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && blocked |=> !dn_req_valid && up_rsp_valid);

    // R5
    quiet_block_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && blocked && !cfg_sec_resp |=> !up_rsp_err && (up_rsp_rdata == '0) && (irq == $past(irq) || $past(irq_clear)));

    // R6
    abort_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && blocked && cfg_sec_resp && !irq_clear |=> up_rsp_err && irq);

    // R7
    clear_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear |=> !irq);

    // R9
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_secure));

    // R12
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid || dn_req_valid) |-> !up_req_ready);

    // R12
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_rsp_valid && !up_rsp_ready |=> up_rsp_valid && $stable(up_rsp_err));

endmodule

bind bus_sec_filter bus_sec_filter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_req_valid (up_req_valid),
    .up_req_ready (up_req_ready),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_ready (up_rsp_ready),
    .up_rsp_err   (up_rsp_err),
    .up_rsp_rdata (up_rsp_rdata),
    .attr_exempt  (attr_exempt),
    .attr_nonsec  (attr_nonsec),
    .cfg_nonsec   (cfg_nonsec),
    .cfg_sec_resp (cfg_sec_resp),
    .irq_clear    (irq_clear),
    .irq          (irq),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_req_addr  (dn_req_addr),
    .dn_req_secure(dn_req_secure)
);

// File: tb/tb_bus_sec_filter.sv
module tb_bus_sec_filter;

    localparam int AW = 32;
    localparam int DW = 64;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_req_valid = 1'b0;
    logic          up_req_ready;
    logic [AW-1:0] up_req_addr = '0;
    logic          up_req_write = 1'b0;
    logic [SW-1:0] up_req_size = '0;
    logic [DW-1:0] up_req_wdata = '0;
    logic          up_rsp_valid;
    logic          up_rsp_ready = 1'b0;
    logic          up_rsp_err;
    logic [DW-1:0] up_rsp_rdata;
    logic          attr_exempt;
    logic          attr_nonsec;
    logic          cfg_nonsec = 1'b0;
    logic          cfg_sec_resp = 1'b0;
    logic          irq_clear = 1'b0;
    logic          irq;
    logic          dn_req_valid;
    logic          dn_req_ready = 1'b0;
    logic [AW-1:0] dn_req_addr;
    logic          dn_req_write;
    logic [SW-1:0] dn_req_size;
    logic [DW-1:0] dn_req_wdata;
    logic          dn_req_secure;
    logic          dn_rsp_valid = 1'b0;
    logic          dn_rsp_ready;
    logic          dn_rsp_err = 1'b0;
    logic [DW-1:0] dn_rsp_rdata = '0;

    always #10 clk = ~clk;

    // Attribution lookup model: bits [9:8]==3 exempt, bit 7 non-secure
    assign attr_exempt = (up_req_addr[9:8] == 2'b11);
    assign attr_nonsec = up_req_addr[7];

    bus_sec_filter dut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] mdl_rdata(input logic [AW-1:0] a);
        return {a ^ 32'h5A5A_C3C3, ~a};
    endfunction

    function automatic logic mdl_err(input logic [AW-1:0] a);
        return a[4] & a[5] & a[6];
    endfunction

    // Downstream model, acts on falling edges
    int            dn_seen = 0;
    logic [AW-1:0] seen_addr;
    logic          seen_write;
    logic [SW-1:0] seen_size;
    logic [DW-1:0] seen_wdata;
    logic          seen_secure;
    int            mst = 0;

    always @(negedge clk) begin
        if (mst == 0) begin
            if (dn_req_valid) begin
                dn_seen++;
                seen_addr   = dn_req_addr;
                seen_write  = dn_req_write;
                seen_size   = dn_req_size;
                seen_wdata  = dn_req_wdata;
                seen_secure = dn_req_secure;
                dn_req_ready = 1'b1;
                mst = 1;
            end
        end else if (mst == 1) begin
            dn_req_ready = 1'b0;
            dn_rsp_valid = 1'b1;
            dn_rsp_err   = mdl_err(seen_addr);
            dn_rsp_rdata = mdl_rdata(seen_addr);
            mst = 2;
        end else begin
            dn_rsp_valid = 1'b0;
            mst = 0;
        end
    end

    logic exp_irq = 1'b0;

    task automatic do_txn(input logic [AW-1:0] a, input logic wr, input logic [SW-1:0] sz,
                          input logic [DW-1:0] wd, input logic ns, input logic sr,
                          input logic clr, input bit flip, input int rsp_wait);
        bit ex, rns, fwd, sec, abort;
        int seen0;
        ex  = (a[9:8] == 2'b11);
        rns = a[7];
        if (ex) begin
            fwd = 1; sec = !ns;
        end else if (rns) begin
            fwd = 1; sec = 0;
        end else if (!ns) begin
            fwd = 1; sec = 1;
        end else begin
            fwd = 0; sec = 0;
        end
        abort = !fwd && sr;

        @(negedge clk);
        irq_clear    = clr;
        cfg_nonsec   = ns;
        cfg_sec_resp = sr;
        up_req_addr  = a;
        up_req_write = wr;
        up_req_size  = sz;
        up_req_wdata = wd;
        up_req_valid = 1'b1;
        seen0 = dn_seen;
        @(posedge clk);
        @(negedge clk);
        up_req_valid = 1'b0;
        // R12: no second acceptance while busy
        chk(up_req_ready == 1'b0, "R12", {63'd0, up_req_ready}, 64'd0);
        if (flip) begin
            cfg_nonsec   = !ns;
            cfg_sec_resp = !sr;
        end
        while (!up_rsp_valid) @(negedge clk);
        repeat (rsp_wait) begin
            @(negedge clk);
            chk(up_rsp_valid && !up_req_ready, "R12", {62'd0, up_rsp_valid, up_req_ready}, 64'd2);
        end
        if (fwd) begin
            chk(dn_seen == seen0 + 1, "R4", 64'(dn_seen - seen0), 64'd1);
            if (ex)
                chk(seen_secure == sec, flip ? "R1/R11" : "R1", {63'd0, seen_secure}, {63'd0, sec});
            else if (rns)
                chk(seen_secure == 1'b0, "R2", {63'd0, seen_secure}, 64'd0);
            else
                chk(seen_secure == 1'b1, flip ? "R3/R11" : "R3", {63'd0, seen_secure}, 64'd1);
            chk({seen_addr, seen_write, seen_size} == {a, wr, sz}, "R9",
                64'({seen_addr, seen_write, seen_size}), 64'({a, wr, sz}));
            chk(seen_wdata == wd, "R9", seen_wdata, wd);
            chk(up_rsp_err == mdl_err(a), "R10", {63'd0, up_rsp_err}, {63'd0, mdl_err(a)});
            chk(up_rsp_rdata == mdl_rdata(a), "R10", up_rsp_rdata, mdl_rdata(a));
        end else begin
            chk(dn_seen == seen0, "R4", 64'(dn_seen - seen0), 64'd0);
            chk(up_rsp_err == abort, abort ? "R6" : "R5", {63'd0, up_rsp_err}, {63'd0, abort});
            chk(up_rsp_rdata == '0, abort ? "R6" : "R5", up_rsp_rdata, '0);
        end
        up_rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        up_rsp_ready = 1'b0;
        chk(up_req_ready == 1'b1, "R12", {63'd0, up_req_ready}, 64'd1);
        if (clr) exp_irq = 1'b0;
        else if (abort) exp_irq = 1'b1;
        chk(irq == exp_irq, clr ? "R7" : (abort ? "R6" : "R5"), {63'd0, irq}, {63'd0, exp_irq});
        cfg_nonsec   = ns;
        cfg_sec_resp = sr;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R8
        chk(irq == 1'b0 && up_req_ready && !dn_req_valid && !up_rsp_valid, "R8",
            {60'd0, irq, up_req_ready, dn_req_valid, up_rsp_valid}, 64'h4);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0 && up_req_ready && !dn_req_valid && !up_rsp_valid, "R8",
            {60'd0, irq, up_req_ready, dn_req_valid, up_rsp_valid}, 64'h4);

        // Directed corner cases
        do_txn(32'h0000_0300, 1'b0, 2'd3, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0); // R1 secure
        do_txn(32'h0000_0370, 1'b1, 2'd0, 64'hAB, 1'b1, 1'b0, 1'b0, 1'b0, 0); // R1 non-secure, R10 err
        do_txn(32'h0000_0080, 1'b1, 2'd1, 64'h1234, 1'b0, 1'b1, 1'b0, 1'b0, 2); // R2
        do_txn(32'h0000_0004, 1'b0, 2'd2, 64'h0, 1'b0, 1'b1, 1'b0, 1'b0, 0); // R3
        do_txn(32'h0000_0010, 1'b0, 2'd3, 64'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1); // R5 quiet
        do_txn(32'h0000_0010, 1'b1, 2'd3, 64'hFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 0); // R6 abort sets irq
        do_txn(32'h0000_0080, 1'b0, 2'd2, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0); // irq stays set
        do_txn(32'h0000_0010, 1'b0, 2'd0, 64'h0, 1'b1, 1'b1, 1'b1, 1'b0, 0); // R7 suppress + clear
        do_txn(32'h0000_0020, 1'b0, 2'd0, 64'h0, 1'b1, 1'b0, 1'b0, 1'b1, 0); // R11 quiet, flipped later
        do_txn(32'h0000_0020, 1'b0, 2'd1, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 0); // R11 secure, flipped later
        do_txn(32'h0000_0300, 1'b0, 2'd1, 64'h0, 1'b1, 1'b0, 1'b0, 1'b1, 0); // R11 exempt

        // Constrained random traffic
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            a = $urandom;
            a[9:8] = ($urandom_range(0, 3) == 0) ? 2'b11 : 2'(($urandom_range(0, 1)));
            do_txn(a, 1'($urandom), 2'($urandom), {$urandom, $urandom},
                   1'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0),
                   ($urandom_range(0, 3) == 0), $urandom_range(0, 2));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule